// File: doc/BRIEF.md
# Chained DMA Channel Register File

This block is the control and pointer store of one DMA channel. Software reaches it through a 32-bit word-addressed register port. It holds a control/status word and five pointer registers: the current pointer, the buffer limit, a chained start, a chained stop and a stored initial-buffer pointer. The control word is not loaded like a plain register. Each write is a set of command bits, and each command bit sets or clears one status flag.

Once the enable flag is set, the channel raises a request toward the device and presents the current pointer as the transfer address. Each acknowledge from the device moves the pointer forward by one word. When the pointer lands on the limit, the buffer is complete. The complete flag is set and the interrupt line rises. If a chained buffer was armed, the channel then moves the start/stop pair into the working pointer/limit pair and keeps running on that second buffer. If no chained buffer was armed, it stops.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset all four status flags are clear, every pointer register reads zero, and `irq` and `dev_req` are low.
- R2: The pointer registers sit at word offsets 0x4000 (current), 0x4004 (limit), 0x4008 (chained start), 0x400C (chained stop) and 0x4200 (initial buffer). Each one reads back the last full-word value written to it.
- R3: An access is accepted only when `acc_be` is 4'hF. A write with any other byte-enable pattern changes nothing, and a read with any other pattern returns zero.
- R4: Offsets that match no register read as zero, and writes to them have no effect.
- R5: The control word is at offset 0x0 and takes these command bits: bit 0 sets enable, bit 1 sets chain-armed, bit 2 sets direction (device to memory). A zero in any of these bits leaves its flag unchanged. The status word reads enable at bit 24, chain-armed at bit 25, complete at bit 26 and direction at bit 27, with all other bits zero. `dev_dir` shows the direction flag.
- R6: Command bit 4 clears the complete flag, and `irq` falls with it.
- R7: Command bit 3 clears enable, chain-armed, complete and direction together. It overrides any set command in the same write.
- R8: While enable is set and the current pointer differs from the limit, `dev_req` is high and `dev_addr` shows the current pointer. Each cycle with `dev_ack` high while `dev_req` is high adds 4 to the current pointer.
- R9: When an accepted acknowledge makes the current pointer equal the limit, the complete flag is set and `irq` stays high until the flag is cleared. If chain-armed is clear at that moment, enable is cleared.
- R10: If chain-armed is set when a buffer completes, the current pointer and the limit are reloaded from the chained start and stop, chain-armed is cleared, and enable stays set.
- R11: A buffer completion in the same cycle as a clear-complete command leaves the complete flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_sel | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte offset of the register |
| acc_be | input | 4 | Byte enables; only 4'hF is accepted |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| dev_req | output | 1 | Transfer request to the device |
| dev_ack | input | 1 | Device acknowledge, one word per cycle |
| dev_addr | output | 32 | Address of the current transfer |
| dev_dir | output | 1 | Direction flag, 1 = device to memory |
| irq | output | 1 | Completion interrupt |

## Verification
The transfer path is run in four patterns, and each one separates a different branch:
- A single buffer of three words with chaining off. This checks that enable drops on completion and that the pointer stops at the limit.
- A two-word buffer chained to a one-word buffer. This checks the reload, the clearing of chain-armed, and that the complete flag remains set across the second buffer.
- A final acknowledge that coincides with a clear-complete write. This shows which of the two wins.
- A buffer whose pointer already equals its limit. Here no request may appear.

The command patterns include an all-zero write, a single bit at a time, and every command bit at once. Together these separate set-only behaviour, the clear command and reset priority.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned OFFS_W = 16;
  localparam int unsigned BE_W   = REG_W / 8;
  localparam int unsigned CMD_W  = 5;
  localparam int unsigned NPTR   = 5;

  // pointer slot indices
  localparam int unsigned IDX_CUR   = 0;
  localparam int unsigned IDX_LIM   = 1;
  localparam int unsigned IDX_CSTRT = 2;
  localparam int unsigned IDX_CSTOP = 3;
  localparam int unsigned IDX_INIT  = 4;

  // register offsets (word aligned)
  localparam logic [OFFS_W-1:0] OFF_CTRL  = 16'h0000;
  localparam logic [OFFS_W-1:0] OFF_CUR   = 16'h4000;
  localparam logic [OFFS_W-1:0] OFF_LIM   = 16'h4004;
  localparam logic [OFFS_W-1:0] OFF_CSTRT = 16'h4008;
  localparam logic [OFFS_W-1:0] OFF_CSTOP = 16'h400C;
  localparam logic [OFFS_W-1:0] OFF_INIT  = 16'h4200;

  // command bit positions
  localparam int unsigned CB_SET_EN  = 0;
  localparam int unsigned CB_SET_CHN = 1;
  localparam int unsigned CB_SET_DIR = 2;
  localparam int unsigned CB_RESET   = 3;
  localparam int unsigned CB_CLR_CMP = 4;

  // status readback positions
  localparam int unsigned SB_EN  = 24;
  localparam int unsigned SB_CHN = 25;
  localparam int unsigned SB_CMP = 26;
  localparam int unsigned SB_DIR = 27;

  typedef struct packed {
    logic clr_cmp;
    logic reset;
    logic set_dir;
    logic set_chn;
    logic set_en;
  } dmach_cmd_t;

  typedef struct packed {
    logic dir;
    logic cmp;
    logic chn;
    logic en;
  } dmach_flags_t;

  function automatic dmach_cmd_t decode_cmd(input logic [CMD_W-1:0] bits);
    dmach_cmd_t c;
    c.set_en  = bits[CB_SET_EN];
    c.set_chn = bits[CB_SET_CHN];
    c.set_dir = bits[CB_SET_DIR];
    c.reset   = bits[CB_RESET];
    c.clr_cmp = bits[CB_CLR_CMP];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input dmach_flags_t f);
    logic [REG_W-1:0] w;
    w         = '0;
    w[SB_EN]  = f.en;
    w[SB_CHN] = f.chn;
    w[SB_CMP] = f.cmp;
    w[SB_DIR] = f.dir;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] ptr_advance(input logic [REG_W-1:0] p,
                                                   input logic [REG_W-1:0] step);
    return p + step;
  endfunction

endpackage

// File: rtl/dmach_bus_if.sv
module dmach_bus_if
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W = OFFS_W
) (
  input  logic                 acc_sel,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [BE_W-1:0]      acc_be,
  input  logic [CMD_W-1:0]     acc_cmd_bits,
  output dmach_cmd_t           cmd,
  output logic [NPTR-1:0]      ptr_we,
  output logic [NPTR-1:0]      ptr_hit,
  output logic                 ctrl_hit,
  output logic                 rd_ok
);

  logic full_word;
  logic wr_ok;
  logic [OFFS_W-1:0] offs;

  assign full_word = (acc_be == {BE_W{1'b1}});
  assign wr_ok     = acc_sel && acc_wr && full_word;
  assign rd_ok     = acc_sel && !acc_wr && full_word;
  assign offs      = OFFS_W'(acc_addr);

  always_comb begin
    ctrl_hit = (offs == OFF_CTRL);
    ptr_hit  = '0;
    ptr_hit[IDX_CUR]   = (offs == OFF_CUR);
    ptr_hit[IDX_LIM]   = (offs == OFF_LIM);
    ptr_hit[IDX_CSTRT] = (offs == OFF_CSTRT);
    ptr_hit[IDX_CSTOP] = (offs == OFF_CSTOP);
    ptr_hit[IDX_INIT]  = (offs == OFF_INIT);
  end

  assign ptr_we = wr_ok ? ptr_hit : '0;
  assign cmd    = (wr_ok && ctrl_hit) ? decode_cmd(acc_cmd_bits) : '0;

  // R4: at most one register decoded per address
  always_comb begin
    p_decode_onehot_r4: assert ($onehot0({ctrl_hit, ptr_hit}))
      else $error("address decoded to several registers");
  end

endmodule

// File: rtl/dmach_ptr_bank.sv
module dmach_ptr_bank
  import dmach_pkg::*;
#(
  parameter int unsigned STEP_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPTR-1:0]              ptr_we,
  input  logic [REG_W-1:0]             wdata,
  input  logic                         fire,
  input  logic                         reload,
  output logic [NPTR-1:0][REG_W-1:0]   ptr_q,
  output logic                         adv_at_limit
);

  localparam logic [REG_W-1:0] STEP = REG_W'(STEP_BYTES);

  logic [REG_W-1:0] cur_adv;

  assign cur_adv      = ptr_advance(ptr_q[IDX_CUR], STEP);
  assign adv_at_limit = (cur_adv == ptr_q[IDX_LIM]);

  // current pointer: bus write > chained reload > advance
  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr_q[IDX_CUR] <= '0;
    else if (ptr_we[IDX_CUR])   ptr_q[IDX_CUR] <= wdata;
    else if (reload)            ptr_q[IDX_CUR] <= ptr_q[IDX_CSTRT];
    else if (fire)              ptr_q[IDX_CUR] <= cur_adv;
  end

  // limit: bus write > chained reload
  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr_q[IDX_LIM] <= '0;
    else if (ptr_we[IDX_LIM])   ptr_q[IDX_LIM] <= wdata;
    else if (reload)            ptr_q[IDX_LIM] <= ptr_q[IDX_CSTOP];
  end

  // plain software-owned slots
  for (genvar gi = IDX_CSTRT; gi < NPTR; gi++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n)          ptr_q[gi] <= '0;
      else if (ptr_we[gi]) ptr_q[gi] <= wdata;
    end
  end

  p_advance_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !reload && !ptr_we[IDX_CUR]) |=>
      ptr_q[IDX_CUR] == $past(ptr_q[IDX_CUR]) + STEP)
    else $error("pointer did not advance by one word");

  p_chain_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !ptr_we[IDX_CUR] && !ptr_we[IDX_LIM]) |=>
      (ptr_q[IDX_CUR] == $past(ptr_q[IDX_CSTRT])) &&
      (ptr_q[IDX_LIM] == $past(ptr_q[IDX_CSTOP])))
    else $error("chained reload took wrong values");

endmodule

// File: rtl/dmach_status.sv
module dmach_status
  import dmach_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  dmach_cmd_t   cmd,
  input  logic         buf_done,
  output dmach_flags_t flags
);

  logic chain_taken;
  assign chain_taken = buf_done && flags.chn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (cmd.reset) begin
      flags <= '0;
    end else begin
      if (cmd.set_en)                  flags.en <= 1'b1;
      else if (buf_done && !flags.chn) flags.en <= 1'b0;

      if (cmd.set_chn)                 flags.chn <= 1'b1;
      else if (chain_taken)            flags.chn <= 1'b0;

      if (buf_done)                    flags.cmp <= 1'b1;
      else if (cmd.clr_cmp)            flags.cmp <= 1'b0;

      if (cmd.set_dir)                 flags.dir <= 1'b1;
    end
  end

  p_done_sets_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !cmd.reset) |=> flags.cmp)
    else $error("completion did not set flag");

  p_reset_cmd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.reset |=> (flags == '0))
    else $error("reset command left a flag set");

  p_dir_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.dir && !cmd.reset) |=> flags.dir)
    else $error("direction flag dropped without reset command");

  p_chain_keeps_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_taken && !cmd.reset) |=> flags.en)
    else $error("enable lost on chained completion");

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W     = OFFS_W,
  parameter int unsigned STEP_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_sel,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [BE_W-1:0]      acc_be,
  input  logic [REG_W-1:0]     acc_wdata,
  output logic [REG_W-1:0]     acc_rdata,
  output logic                 dev_req,
  input  logic                 dev_ack,
  output logic [REG_W-1:0]     dev_addr,
  output logic                 dev_dir,
  output logic                 irq
);

  dmach_cmd_t                  cmd;
  dmach_flags_t                flags;
  logic [NPTR-1:0]             ptr_we;
  logic [NPTR-1:0]             ptr_hit;
  logic                        ctrl_hit;
  logic                        rd_ok;
  logic [NPTR-1:0][REG_W-1:0]  ptr_q;
  logic                        adv_at_limit;

  // named internal events
  logic xfer_fire;
  logic buf_done;
  logic chain_reload;

  dmach_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .acc_sel      (acc_sel),
    .acc_wr       (acc_wr),
    .acc_addr     (acc_addr),
    .acc_be       (acc_be),
    .acc_cmd_bits (acc_wdata[CMD_W-1:0]),
    .cmd          (cmd),
    .ptr_we       (ptr_we),
    .ptr_hit      (ptr_hit),
    .ctrl_hit     (ctrl_hit),
    .rd_ok        (rd_ok)
  );

  dmach_ptr_bank #(.STEP_BYTES(STEP_BYTES)) u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_we       (ptr_we),
    .wdata        (acc_wdata),
    .fire         (xfer_fire),
    .reload       (chain_reload),
    .ptr_q        (ptr_q),
    .adv_at_limit (adv_at_limit)
  );

  dmach_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .buf_done (buf_done),
    .flags    (flags)
  );

  assign dev_req      = flags.en && (ptr_q[IDX_CUR] != ptr_q[IDX_LIM]);
  assign xfer_fire    = dev_req && dev_ack;
  assign buf_done     = xfer_fire && adv_at_limit;
  assign chain_reload = buf_done && flags.chn;

  assign dev_addr = ptr_q[IDX_CUR];
  assign dev_dir  = flags.dir;
  assign irq      = flags.cmp;

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) begin
      if (ctrl_hit) acc_rdata = status_word(flags);
      for (int i = 0; i < NPTR; i++) begin
        if (ptr_hit[i]) acc_rdata = acc_rdata | ptr_q[i];
      end
    end
  end

  p_narrow_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && acc_wr && acc_be != {BE_W{1'b1}} && !xfer_fire) |=>
      $stable(ptr_q[IDX_CUR]) && $stable(flags))
    else $error("narrow write changed state");

  p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd.clr_cmp && !cmd.reset) |=> irq)
    else $error("irq dropped without clear");

  p_no_req_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.en && !cmd.set_en) |=> !dev_req)
    else $error("request without enable");

endmodule

// File: tb/dma_chain_channel_tb.sv
`timescale 1ns/100ps
module dma_chain_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_sel = 1'b0;
  logic        acc_wr = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        dev_req;
  logic        dev_ack = 1'b0;
  logic [31:0] dev_addr;
  logic        dev_dir;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // status bit values (R5)
  localparam logic [31:0] ST_EN  = 32'h0100_0000;
  localparam logic [31:0] ST_CHN = 32'h0200_0000;
  localparam logic [31:0] ST_CMP = 32'h0400_0000;
  localparam logic [31:0] ST_DIR = 32'h0800_0000;

  always #2.5 clk = ~clk;

  dma_chain_channel u_dut (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_addr(dev_addr), .dev_dir(dev_dir), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    acc_sel = 1; acc_wr = 1; acc_addr = a; acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_sel = 0; acc_wr = 0; acc_be = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    acc_sel = 1; acc_wr = 0; acc_addr = a; acc_be = be;
    #1 d = acc_rdata;
    acc_sel = 0; acc_be = 0;
  endtask

  task automatic ack1();
    @(negedge clk);
    dev_ack = 1;
    @(negedge clk);
    dev_ack = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(16'h0000, v);  chk("R1 status", v, 32'h0);
    rd(16'h4000, v);  chk("R1 current", v, 32'h0);
    rd(16'h4200, v);  chk("R1 initbuf", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dev_req", {31'b0, dev_req}, 32'h0);
  endtask

  task automatic t_pointer_rw();
    logic [31:0] v;
    wr(16'h4000, 32'h1111_0000);
    wr(16'h4004, 32'h2222_0004);
    wr(16'h4008, 32'h3333_0008);
    wr(16'h400C, 32'h4444_000C);
    wr(16'h4200, 32'h5555_0200);
    rd(16'h4000, v); chk("R2 current", v, 32'h1111_0000);
    rd(16'h4004, v); chk("R2 limit", v, 32'h2222_0004);
    rd(16'h4008, v); chk("R2 chained start", v, 32'h3333_0008);
    rd(16'h400C, v); chk("R2 chained stop", v, 32'h4444_000C);
    rd(16'h4200, v); chk("R2 initbuf", v, 32'h5555_0200);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    wr(16'h4000, 32'hDEAD_BEEF, 4'h3);
    rd(16'h4000, v); chk("R3 narrow write ignored", v, 32'h1111_0000);
    rd(16'h4000, v, 4'h1); chk("R3 narrow read zero", v, 32'h0);
    wr(16'h0000, 32'h0000_0001, 4'h7);
    rd(16'h0000, v); chk("R3 narrow ctrl write ignored", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(16'h4010, 32'hFFFF_FFFF);
    rd(16'h4010, v); chk("R4 unmapped read", v, 32'h0);
    rd(16'h4000, v); chk("R4 unmapped write no effect", v, 32'h1111_0000);
    rd(16'h0004, v); chk("R4 unmapped near ctrl", v, 32'h0);
  endtask

  task automatic t_cmd_bits();
    logic [31:0] v;
    wr(16'h0000, 32'h0000_0004);
    rd(16'h0000, v); chk("R5 set dir", v, ST_DIR);
    chk("R5 dev_dir", {31'b0, dev_dir}, 32'h1);
    wr(16'h0000, 32'h0000_0000);
    rd(16'h0000, v); chk("R5 zero write keeps flags", v, ST_DIR);
    wr(16'h0000, 32'h0000_0002);
    rd(16'h0000, v); chk("R5 set chain", v, ST_DIR | ST_CHN);
    wr(16'h0000, 32'h0000_001F);
    rd(16'h0000, v); chk("R7 reset wins over sets", v, 32'h0);
    chk("R7 dev_dir cleared", {31'b0, dev_dir}, 32'h0);
  endtask

  task automatic t_single_buffer();
    logic [31:0] v;
    wr(16'h4000, 32'h0000_0100);
    wr(16'h4004, 32'h0000_010C);
    wr(16'h0000, 32'h0000_0001);
    chk("R8 request raised", {31'b0, dev_req}, 32'h1);
    chk("R8 dev_addr", dev_addr, 32'h0000_0100);
    ack1();
    chk("R8 advance 1", dev_addr, 32'h0000_0104);
    ack1();
    chk("R8 advance 2", dev_addr, 32'h0000_0108);
    chk("R9 no early irq", {31'b0, irq}, 32'h0);
    ack1();
    chk("R9 pointer at limit", dev_addr, 32'h0000_010C);
    chk("R9 irq up", {31'b0, irq}, 32'h1);
    chk("R9 request dropped", {31'b0, dev_req}, 32'h0);
    rd(16'h0000, v); chk("R9 complete, enable off", v, ST_CMP);
    repeat (3) @(negedge clk);
    chk("R9 irq held", {31'b0, irq}, 32'h1);
    wr(16'h0000, 32'h0000_0010);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    rd(16'h0000, v); chk("R6 status after clear", v, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    wr(16'h4000, 32'h0000_0200);
    wr(16'h4004, 32'h0000_0208);
    wr(16'h4008, 32'h0000_0300);
    wr(16'h400C, 32'h0000_0304);
    wr(16'h0000, 32'h0000_0003);
    rd(16'h0000, v); chk("R10 armed", v, ST_EN | ST_CHN);
    ack1();
    ack1();
    rd(16'h0000, v); chk("R10 chained: enable kept, chain cleared", v, ST_EN | ST_CMP);
    rd(16'h4000, v); chk("R10 current reloaded", v, 32'h0000_0300);
    rd(16'h4004, v); chk("R10 limit reloaded", v, 32'h0000_0304);
    chk("R10 request continues", {31'b0, dev_req}, 32'h1);
    ack1();
    rd(16'h0000, v); chk("R10 second buffer ends", v, ST_CMP);
    chk("R10 final pointer", dev_addr, 32'h0000_0304);
    wr(16'h0000, 32'h0000_0010);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(16'h4000, 32'h0000_0400);
    wr(16'h4004, 32'h0000_0404);
    wr(16'h0000, 32'h0000_0001);
    @(negedge clk);
    dev_ack = 1;
    acc_sel = 1; acc_wr = 1; acc_addr = 16'h0000; acc_wdata = 32'h10; acc_be = 4'hF;
    @(negedge clk);
    dev_ack = 0; acc_sel = 0; acc_wr = 0; acc_be = 0;
    chk("R11 completion beats clear", {31'b0, irq}, 32'h1);
    rd(16'h0000, v); chk("R11 status", v, ST_CMP);
    wr(16'h0000, 32'h0000_0010);
  endtask

  task automatic t_empty_buffer();
    wr(16'h4000, 32'h0000_0500);
    wr(16'h4004, 32'h0000_0500);
    wr(16'h0000, 32'h0000_0001);
    chk("R8 no request when current equals limit", {31'b0, dev_req}, 32'h0);
    ack1();
    chk("R8 ack ignored without request", dev_addr, 32'h0000_0500);
    wr(16'h0000, 32'h0000_0008);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_pointer_rw();
    t_narrow();
    t_unmapped();
    t_cmd_bits();
    t_single_buffer();
    t_chain();
    t_collision();
    t_empty_buffer();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule